// File: doc/BRIEF.md
# Layout-Invariant Three-Step Number-Theoretic Transform

This block turns a length-N polynomial, held as an R-by-C row-major array, into its cyclic number-theoretic transform modulo a prime q. It does this in three matrix passes over one modular multiply-accumulate unit. First, an R-by-R matrix multiplies every column of the working array. Second, each entry is scaled by a per-position cross twiddle. Third, a C-by-C matrix multiplies each row of the scaled array, and the result is written out in natural index order. There is no explicit transpose pass and no bit-reverse pass. Any reordering is folded into the contents of the three tables and into the read pattern of the last pass.

The three tables are written through a simple write port while the block is idle. A host computes and loads them. A start pulse opens a load window. In that window N coefficients enter over a valid/ready stream, and each coefficient must already be below q. The block then computes with no further input. After that, N results leave over a second valid/ready stream, and a done pulse marks the end. The input side accepts a beat only while `in_ready` is high, and a sender may hold `in_valid` low for any number of cycles. On the output side, once `out_valid` is high, `out_valid` and `out_data` stay unchanged until a cycle with `out_ready` high takes the beat.

Top module: `ntt3_core`

## Requirements
- R1: While reset is applied and in the first cycle after it, `in_ready`, `out_valid` and `done` are all low.
- R2: A start pulse in idle raises `in_ready`. It stays high until exactly N coefficients have been accepted, and after the N-th it drops.
- R3: With A[k1*R+n1] = w^(C*n1*k1), T[k1*C+n2] = w^(n2*k1) and B[k2*C+n2] = w^(R*n2*k2), where w is a primitive N-th root of unity mod q, the m-th output beat equals sum over n of x[n]*w^(n*m) mod q, for m = 0..N-1.
- R4: Every output value is below q.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: `done` is high for exactly one cycle, the cycle after the last output beat is taken, and `out_valid` is low in that cycle.
- R7: Table writes are taken only in idle. A write made during a transform changes neither that transform's results nor later ones.
- R8: The first output is valid exactly N*R + N + N*C clock edges after the edge that accepts the last input (144 for the defaults).
- R9: For any table contents, output beat m = R*k2 + k1 equals sum over n2 of B[k2*C+n2] * T[k1*C+n2] * (sum over n1 of A[k1*R+n1] * x[n1*C+n2]), all mod q. With identity A and B and an all-ones T, beat m therefore returns x[C*(m mod R) + m div R].
- R10: A start pulse outside idle has no effect. The running transform completes unchanged, and no new load window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transform (acted on in idle only) |
| done | output | 1 | One-cycle pulse after the last result is taken |
| tbl_we | input | 1 | Table write enable (acted on in idle only) |
| tbl_sel | input | 2 | Table select: 0 column matrix A, 1 cross twiddles T, 2 row matrix B |
| tbl_addr | input | ADR_W | Entry index in the selected table, row-major |
| tbl_data | input | W | Entry value, below q |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block can take a coefficient |
| in_data | input | W | Input coefficient, natural order, below q |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Receiver takes the result |
| out_data | output | W | Result, natural order |

## Verification
The main function is tried on several inputs. The all-zero vector rules out stale state. Impulses at index 0 and index 1 separate a constant response from the power sequence of the root. A constant input puts all of its energy in bin 0 and checks the reduction of N copies. A ramp and two pseudo-random vectors mix every table entry. An all-(q-1) vector pushes every accumulation to its largest operands. Identity tables turn the datapath into a pure reorder, which exposes any mistake in the read order of the last pass separately from the arithmetic. Output stalls, spurious start pulses and table writes made mid-transform test the stream and control rules against results that are already known.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COL,
    ST_TWID,
    ST_ROW,
    ST_OUT
  } nt_state_e;

  localparam logic [1:0] SEL_COLMAT = 2'd0;
  localparam logic [1:0] SEL_TWID   = 2'd1;
  localparam logic [1:0] SEL_ROWMAT = 2'd2;
endpackage

// File: rtl/nt_modmac.sv
module nt_modmac #(
  parameter int          W = 28,
  parameter int unsigned Q = 12289
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res
);
  localparam logic [2*W-1:0] Q_WIDE = (2*W)'(Q);
  localparam logic [W:0]     Q_SUM  = (W+1)'(Q);

  logic [2*W-1:0] prod;
  logic [W-1:0]   prod_red;
  logic [W:0]     sum;

  always_comb begin
    prod     = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
    prod_red = W'(prod % Q_WIDE);
    sum      = {1'b0, acc_in} + {1'b0, prod_red};
    res      = (sum >= Q_SUM) ? W'(sum - Q_SUM) : sum[W-1:0];
  end

  // R4: every accumulated partial result stays reduced
  a_r4_mac_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (res < W'(Q)));
endmodule

// File: rtl/nt_seq.sv
module nt_seq
  import nt_pkg::*;
#(
  parameter int LOG_R = 2,
  parameter int LOG_C = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_fire,
  input  logic                   out_fire,
  output nt_state_e              state,
  output logic [LOG_R+LOG_C-1:0] elem,
  output logic [TW-1:0]          term,
  output logic                   term_first,
  output logic                   wr_en,
  output logic                   done
);
  localparam int LOG_N = LOG_R + LOG_C;
  localparam int N     = 1 << LOG_N;
  localparam int R     = 1 << LOG_R;
  localparam int C     = 1 << LOG_C;
  localparam int TW    = (LOG_R > LOG_C) ? LOG_R : LOG_C;
  localparam logic [LOG_N-1:0] E_LAST = LOG_N'(N - 1);

  logic [TW-1:0] term_lim;
  logic          computing;
  logic          term_end;
  logic          elem_end;

  always_comb begin
    unique case (state)
      ST_COL:  term_lim = TW'(R - 1);
      ST_ROW:  term_lim = TW'(C - 1);
      default: term_lim = '0;
    endcase
    computing  = (state == ST_COL) || (state == ST_TWID) || (state == ST_ROW);
    term_end   = (term == term_lim);
    elem_end   = (elem == E_LAST);
    term_first = (term == '0);
    wr_en      = computing && term_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      elem  <= '0;
      term  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          elem  <= '0;
          term  <= '0;
        end
        ST_LOAD: if (in_fire) begin
          elem <= elem_end ? '0 : elem + 1'b1;
          if (elem_end) state <= ST_COL;
        end
        ST_COL, ST_TWID, ST_ROW: begin
          if (term_end) begin
            term <= '0;
            elem <= elem_end ? '0 : elem + 1'b1;
            if (elem_end) begin
              if (state == ST_COL)       state <= ST_TWID;
              else if (state == ST_TWID) state <= ST_ROW;
              else                       state <= ST_OUT;
            end
          end else begin
            term <= term + 1'b1;
          end
        end
        ST_OUT: if (out_fire) begin
          elem <= elem_end ? '0 : elem + 1'b1;
          if (elem_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the pulse follows a taken output beat
  a_r6_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_fire));
  // R10: a start outside idle never reopens the load window
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE && state != ST_OUT) |=> state != ST_IDLE);
endmodule

// File: rtl/ntt3_core.sv
module ntt3_core
  import nt_pkg::*;
#(
  parameter int          W     = 28,
  parameter int unsigned Q     = 12289,
  parameter int          LOG_R = 2,
  parameter int          LOG_C = 2,
  parameter int          ADR_W = (LOG_R > LOG_C) ? 2*LOG_R : 2*LOG_C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  input  logic             tbl_we,
  input  logic [1:0]       tbl_sel,
  input  logic [ADR_W-1:0] tbl_addr,
  input  logic [W-1:0]     tbl_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data
);
  localparam int LOG_N = LOG_R + LOG_C;
  localparam int N     = 1 << LOG_N;
  localparam int R     = 1 << LOG_R;
  localparam int C     = 1 << LOG_C;
  localparam int TW    = (LOG_R > LOG_C) ? LOG_R : LOG_C;

  logic [W-1:0] tab_col [R*R];
  logic [W-1:0] tab_twd [N];
  logic [W-1:0] tab_row [C*C];
  logic [W-1:0] buf_x   [N];
  logic [W-1:0] buf_y   [N];

  nt_state_e        state;
  logic [LOG_N-1:0] elem;
  logic [TW-1:0]    term;
  logic             term_first;
  logic             wr_en;
  logic             in_fire;
  logic             out_fire;
  logic [W-1:0]     acc;
  logic [W-1:0]     acc_in;
  logic [W-1:0]     op_a;
  logic [W-1:0]     op_b;
  logic [W-1:0]     mac_res;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_OUT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_data  = buf_x[elem];
  assign acc_in    = term_first ? '0 : acc;

  nt_seq #(.LOG_R(LOG_R), .LOG_C(LOG_C)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_fire    (in_fire),
    .out_fire   (out_fire),
    .state      (state),
    .elem       (elem),
    .term       (term),
    .term_first (term_first),
    .wr_en      (wr_en),
    .done       (done)
  );

  // Operand selection: the last pass reads the scaled array column-wise,
  // which places results in natural order without a transpose pass.
  always_comb begin
    op_a = '0;
    op_b = '0;
    unique case (state)
      ST_COL: begin
        op_a = tab_col[{elem[LOG_N-1:LOG_C], term[LOG_R-1:0]}];
        op_b = buf_x[{term[LOG_R-1:0], elem[LOG_C-1:0]}];
      end
      ST_TWID: begin
        op_a = tab_twd[elem];
        op_b = buf_y[elem];
      end
      ST_ROW: begin
        op_a = tab_row[{elem[LOG_N-1:LOG_R], term[LOG_C-1:0]}];
        op_b = buf_y[{elem[LOG_R-1:0], term[LOG_C-1:0]}];
      end
      default: ;
    endcase
  end

  nt_modmac #(.W(W), .Q(Q)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (wr_en),
    .acc_in (acc_in),
    .op_a   (op_a),
    .op_b   (op_b),
    .res    (mac_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= mac_res;
  end

  always_ff @(posedge clk) begin
    if (tbl_we && state == ST_IDLE) begin
      unique case (tbl_sel)
        SEL_COLMAT: tab_col[tbl_addr[2*LOG_R-1:0]] <= tbl_data;
        SEL_TWID:   tab_twd[tbl_addr[LOG_N-1:0]]   <= tbl_data;
        SEL_ROWMAT: tab_row[tbl_addr[2*LOG_C-1:0]] <= tbl_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire)
      buf_x[elem] <= in_data;
    else if (wr_en && state == ST_ROW)
      buf_x[elem] <= mac_res;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (state == ST_COL || state == ST_TWID))
      buf_y[elem] <= mac_res;
  end

  // R5: a stalled output beat is held unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R4: results leaving the block are reduced
  a_r4_out_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data < W'(Q)));
  // R2: input and output windows never overlap
  a_r2_windows: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R6: no output beat is offered in the completion cycle
  a_r6_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

// File: tb/tb_ntt3_core.sv
module tb_ntt3_core;
  localparam int    W     = 28;
  localparam longint Q    = 12289;
  localparam int    LOG_R = 2;
  localparam int    LOG_C = 2;
  localparam int    R     = 1 << LOG_R;
  localparam int    C     = 1 << LOG_C;
  localparam int    N     = R * C;
  localparam int    ADR_W = 4;
  localparam int    LAT   = N*R + N + N*C;
  // pattern kind, parameter: 0 zero, 1 impulse at p, 2 constant p,
  // 3 ramp, 4 all q-1, 5 pseudo-random seeded by p
  localparam int PAT [8][2] = '{'{0,0}, '{1,0}, '{1,1}, '{2,5},
                                '{3,0}, '{4,0}, '{5,123}, '{5,4567}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic [ADR_W-1:0] tbl_addr = '0;
  logic [W-1:0] tbl_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  longint w;
  longint xin [N];

  always #10 clk = ~clk;

  ntt3_core #(.W(W), .Q(Q), .LOG_R(LOG_R), .LOG_C(LOG_C)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mpow(input longint b, input longint e);
    longint r = 1;
    longint bb = b % Q;
    longint ee = e;
    while (ee > 0) begin
      if (ee[0]) r = (r * bb) % Q;
      bb = (bb * bb) % Q;
      ee = ee >> 1;
    end
    return r;
  endfunction

  function automatic longint pat(input int kind, input int p, input int n);
    case (kind)
      0: return 0;
      1: return (n == p) ? 1 : 0;
      2: return p;
      3: return n;
      4: return Q - 1;
      default: return (longint'(p) * (n + 3) * (n + 7) + n * 977) % Q;
    endcase
  endfunction

  function automatic longint ref_ntt(input int m);
    longint s = 0;
    for (int n = 0; n < N; n++) s = (s + xin[n] * mpow(w, (n * m) % N)) % Q;
    return s;
  endfunction

  task automatic wr_tbl(input int sel, input int addr, input longint val);
    tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_addr = ADR_W'(addr); tbl_data = W'(val);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_tables(input bit ident);
    for (int k = 0; k < R; k++)
      for (int n = 0; n < R; n++)
        wr_tbl(0, k*R + n, ident ? ((k == n) ? 1 : 0) : mpow(w, (C*n*k) % N));
    for (int k = 0; k < R; k++)
      for (int n = 0; n < C; n++)
        wr_tbl(1, k*C + n, ident ? 1 : mpow(w, (n*k) % N));
    for (int k = 0; k < C; k++)
      for (int n = 0; n < C; n++)
        wr_tbl(2, k*C + n, ident ? ((k == n) ? 1 : 0) : mpow(w, (R*n*k) % N));
  endtask

  task automatic run_tx(input int kind, input int p, input bit stall, input bit poke, input bit ident);
    int cnt;
    longint d0, exp;
    for (int n = 0; n < N; n++) xin[n] = pat(kind, p, n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < N; n++) begin
      if (n == 5) @(negedge clk);
      in_valid = 1'b1; in_data = W'(xin[n]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    chk(in_ready == 1'b0, "R2 window closes", in_ready, 0);
    cnt = 0;
    while (!out_valid && cnt < 4*LAT) begin
      if (poke && cnt == 5) begin
        start = 1'b1;
        tbl_we = 1'b1; tbl_sel = 2'd0; tbl_addr = '0; tbl_data = W'(999);
      end else begin
        start = 1'b0; tbl_we = 1'b0;
      end
      @(negedge clk);
      cnt++;
      if (poke && cnt == 6) chk(in_ready == 1'b0, "R10 no reload", in_ready, 0);
    end
    start = 1'b0; tbl_we = 1'b0;
    chk(cnt == LAT, "R8 latency", cnt, LAT);
    for (int m = 0; m < N; m++) begin
      if (ident) exp = xin[C*(m % R) + m / R];
      else       exp = ref_ntt(m);
      if (stall) begin
        d0 = out_data;
        repeat (2) @(negedge clk);
        chk(out_valid && out_data == W'(d0), "R5 hold", out_data, d0);
      end
      chk(out_data == W'(exp), ident ? "R9 reorder" : (poke ? "R3/R7/R10 value" : "R3 value"),
          out_data, exp);
      chk(out_data < W'(Q), "R4 reduced", out_data, Q - 1);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      if (m < N-1) chk(done == 1'b0, "R6 early done", done, 0);
    end
    chk(done == 1'b1 && out_valid == 1'b0, "R6 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    w = mpow(11, (Q - 1) / N);
    #1;
    chk(in_ready == 0 && out_valid == 0 && done == 0, "R1 in reset", {in_ready, out_valid, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 0 && out_valid == 0 && done == 0, "R1 after reset", {in_ready, out_valid, done}, 0);
    chk(mpow(w, N/2) == Q - 1, "R3 root order", mpow(w, N/2), Q - 1);
    load_tables(1'b0);
    for (int i = 0; i < 8; i++)
      run_tx(PAT[i][0], PAT[i][1], i % 2 == 1, i == 3, 1'b0);
    // R7: the table write poked during pattern 3 must not have landed
    run_tx(5, 77, 1'b0, 1'b0, 1'b0);
    load_tables(1'b1);
    run_tx(3, 0, 1'b0, 1'b0, 1'b1);
    run_tx(5, 31, 1'b1, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule